// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates 32-bit virtual addresses to physical addresses using a small, fully associative translation cache. Each entry describes two neighbouring 4 KB pages, an even one and an odd one. The two pages share one tag, one address-space identifier and one global flag. Each page has its own frame number, valid bit and dirty bit. A lookup request carries a virtual address, an access direction and the current 8-bit address-space identifier. One cycle later the block returns the physical address, a writable flag and a two-bit result code.

The refill path is a plain write port. On one clock edge it replaces every field of the entry at a given index. A software handler or a hardware table walker can drive it. All entries are compared in parallel. When more than one entry hits, the entry with the lowest index wins. The surrounding pipeline uses the result code to decide whether to raise a refill, invalid-page or modify exception.

Top module: `tlbp_lookup`

## Requirements
- R1: An entry hits when its stored page-pair tag equals virtual address bits [31:13] and either its global bit is set or its stored identifier equals `lk_asid`; an entry with neither condition does not hit.
- R2: Address bit 12 picks the half of the hit entry (1 = odd, 0 = even); on a match the physical address is that half's frame number followed by address bits [11:0].
- R3: When the selected half has its valid bit clear, the code is 2'b10 (invalid) for both reads and writes.
- R4: A read of a valid half, or a write to a valid half whose dirty bit is set, gives code 2'b00 (match); `rsp_writable` equals the selected half's dirty bit.
- R5: A write to a valid half whose dirty bit is clear gives code 2'b11 (modify fault).
- R6: When no entry hits, the code is 2'b01 (no match).
- R7: When several entries hit, the result comes from the entry with the lowest index.
- R8: Whenever the code is not 2'b00, `rsp_paddr` is zero and `rsp_writable` is low.
- R9: A request presented with `lk_valid` high in one cycle produces `rsp_valid` high with its result in the next cycle. In a cycle after no request, `rsp_valid` is low and the other response outputs are zero.
- R10: An entry written with `wr_en` is used by lookups presented in the following cycle and later. A lookup presented in the same cycle as the write still sees the old contents.
- R11: After reset, every entry has a zero tag, zero identifier, clear global bit and both halves invalid. So page pair 0 under identifier 0 reports invalid, and other page pairs report no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = store access, 0 = load access |
| lk_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_tag | input | 19 | Page-pair tag (virtual address bits [31:13]) |
| wr_asid | input | 8 | Identifier stored with the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_pfn_even | input | 20 | Frame number of the even half |
| wr_valid_even | input | 1 | Even half valid |
| wr_dirty_even | input | 1 | Even half writable |
| wr_pfn_odd | input | 20 | Frame number of the odd half |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_dirty_odd | input | 1 | Odd half writable |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_writable | output | 1 | Selected half permits stores |
| rsp_code | output | 2 | 00 match, 01 no match, 10 invalid, 11 modify |

## Verification
The bench builds the block with its default parameters: 16 entries, an 8-bit identifier and 32-bit virtual and physical addresses. With these values the last index (15) and the topmost page pair (tag 0x7FFFF) are within reach. The bench places a global entry there. Two entries with identical tags at non-adjacent indices (5 and 9) test the lowest-index priority. It then rewrites the winner to show the fallback to the other entry. A write and a lookup in the same cycle show which entry contents the response uses.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    localparam int unsigned PAGE_OFS_W = 12;

    typedef enum logic [1:0] {
        RC_HIT     = 2'b00,
        RC_MISS    = 2'b01,
        RC_INVALID = 2'b10,
        RC_MODIFY  = 2'b11
    } tlbp_code_e;

    localparam logic HALF_EVEN = 1'b0;
    localparam logic HALF_ODD  = 1'b1;

endpackage

// File: rtl/tlbp_entry_array.sv
module tlbp_entry_array #(
    parameter int unsigned NUM_ENT = 16,
    parameter int unsigned TAG_W   = 19,
    parameter int unsigned ASID_W  = 8,
    parameter int unsigned PFN_W   = 20,
    localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic [ASID_W-1:0]                 wr_asid,
    input  logic                              wr_global,
    input  logic [1:0][PFN_W-1:0]             wr_pfn,
    input  logic [1:0]                        wr_vld,
    input  logic [1:0]                        wr_dty,
    output logic [NUM_ENT-1:0][TAG_W-1:0]     ent_tag,
    output logic [NUM_ENT-1:0][ASID_W-1:0]    ent_asid,
    output logic [NUM_ENT-1:0]                ent_glb,
    output logic [NUM_ENT-1:0][1:0][PFN_W-1:0] ent_pfn,
    output logic [NUM_ENT-1:0][1:0]           ent_vld,
    output logic [NUM_ENT-1:0][1:0]           ent_dty
);

    typedef struct packed {
        logic [TAG_W-1:0]      tag;
        logic [ASID_W-1:0]     asid;
        logic                  glb;
        logic [1:0][PFN_W-1:0] pfn;
        logic [1:0]            vld;
        logic [1:0]            dty;
    } ent_t;

    ent_t [NUM_ENT-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            ent_d[wr_idx].tag  = wr_tag;
            ent_d[wr_idx].asid = wr_asid;
            ent_d[wr_idx].glb  = wr_global;
            ent_d[wr_idx].pfn  = wr_pfn;
            ent_d[wr_idx].vld  = wr_vld;
            ent_d[wr_idx].dty  = wr_dty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_out
        assign ent_tag[g]  = ent_q[g].tag;
        assign ent_asid[g] = ent_q[g].asid;
        assign ent_glb[g]  = ent_q[g].glb;
        assign ent_pfn[g]  = ent_q[g].pfn;
        assign ent_vld[g]  = ent_q[g].vld;
        assign ent_dty[g]  = ent_q[g].dty;
    end

endmodule

// File: rtl/tlbp_match.sv
module tlbp_match #(
    parameter int unsigned NUM_ENT = 16,
    parameter int unsigned TAG_W   = 19,
    parameter int unsigned ASID_W  = 8,
    localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0][TAG_W-1:0]  ent_tag,
    input  logic [NUM_ENT-1:0][ASID_W-1:0] ent_asid,
    input  logic [NUM_ENT-1:0]             ent_glb,
    input  logic [TAG_W-1:0]               req_tag,
    input  logic [ASID_W-1:0]              req_asid,
    output logic                           hit_any,
    output logic [IDX_W-1:0]               hit_idx
);

    logic [NUM_ENT-1:0] hit_vec;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic tag_eq;
        logic id_ok;
        assign tag_eq     = (ent_tag[g] == req_tag);
        assign id_ok      = ent_glb[g] || (ent_asid[g] == req_asid);
        assign hit_vec[g] = tag_eq && id_ok;
    end

    // Scan from the top down so the lowest hitting index is the last to assign.
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
        hit_any = |hit_vec;
    end

endmodule

// File: rtl/tlbp_resolve.sv
module tlbp_resolve
    import tlbp_pkg::*;
#(
    parameter int unsigned NUM_ENT = 16,
    parameter int unsigned PFN_W   = 20,
    localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int unsigned PA_W   = PFN_W + PAGE_OFS_W
) (
    input  logic [NUM_ENT-1:0][1:0][PFN_W-1:0] ent_pfn,
    input  logic [NUM_ENT-1:0][1:0]            ent_vld,
    input  logic [NUM_ENT-1:0][1:0]            ent_dty,
    input  logic                               hit_any,
    input  logic [IDX_W-1:0]                   hit_idx,
    input  logic                               half_sel,
    input  logic                               is_write,
    input  logic [PAGE_OFS_W-1:0]              page_ofs,
    output tlbp_code_e                         res_code,
    output logic [PA_W-1:0]                    res_paddr,
    output logic                               res_writable
);

    logic [PFN_W-1:0] sel_pfn;
    logic             sel_vld;
    logic             sel_dty;

    always_comb begin
        sel_pfn = ent_pfn[hit_idx][half_sel];
        sel_vld = ent_vld[hit_idx][half_sel];
        sel_dty = ent_dty[hit_idx][half_sel];

        res_code     = RC_MISS;
        res_paddr    = '0;
        res_writable = 1'b0;

        if (hit_any) begin
            if (!sel_vld) begin
                res_code = RC_INVALID;
            end else if (is_write && !sel_dty) begin
                res_code = RC_MODIFY;
            end else begin
                res_code     = RC_HIT;
                res_paddr    = {sel_pfn, page_ofs};
                res_writable = sel_dty;
            end
        end
    end

endmodule

// File: rtl/tlbp_lookup.sv
module tlbp_lookup
    import tlbp_pkg::*;
#(
    parameter int unsigned NUM_ENT = 16,
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned ASID_W  = 8,
    localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int unsigned TAG_W  = VA_W - PAGE_OFS_W - 1,
    localparam int unsigned PFN_W  = PA_W - PAGE_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_valid_even,
    input  logic              wr_dirty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_valid_odd,
    input  logic              wr_dirty_odd,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_writable,
    output logic [1:0]        rsp_code
);

    logic [NUM_ENT-1:0][TAG_W-1:0]      ent_tag;
    logic [NUM_ENT-1:0][ASID_W-1:0]     ent_asid;
    logic [NUM_ENT-1:0]                 ent_glb;
    logic [NUM_ENT-1:0][1:0][PFN_W-1:0] ent_pfn;
    logic [NUM_ENT-1:0][1:0]            ent_vld;
    logic [NUM_ENT-1:0][1:0]            ent_dty;

    logic [1:0][PFN_W-1:0] wr_pfn;
    logic [1:0]            wr_vld;
    logic [1:0]            wr_dty;

    assign wr_pfn = {wr_pfn_odd, wr_pfn_even};
    assign wr_vld = {wr_valid_odd, wr_valid_even};
    assign wr_dty = {wr_dirty_odd, wr_dirty_even};

    tlbp_entry_array #(
        .NUM_ENT (NUM_ENT),
        .TAG_W   (TAG_W),
        .ASID_W  (ASID_W),
        .PFN_W   (PFN_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_asid   (wr_asid),
        .wr_global (wr_global),
        .wr_pfn    (wr_pfn),
        .wr_vld    (wr_vld),
        .wr_dty    (wr_dty),
        .ent_tag   (ent_tag),
        .ent_asid  (ent_asid),
        .ent_glb   (ent_glb),
        .ent_pfn   (ent_pfn),
        .ent_vld   (ent_vld),
        .ent_dty   (ent_dty)
    );

    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;

    tlbp_match #(
        .NUM_ENT (NUM_ENT),
        .TAG_W   (TAG_W),
        .ASID_W  (ASID_W)
    ) u_match (
        .ent_tag  (ent_tag),
        .ent_asid (ent_asid),
        .ent_glb  (ent_glb),
        .req_tag  (lk_vaddr[VA_W-1:PAGE_OFS_W+1]),
        .req_asid (lk_asid),
        .hit_any  (hit_any),
        .hit_idx  (hit_idx)
    );

    tlbp_code_e      res_code;
    logic [PA_W-1:0] res_paddr;
    logic            res_writable;

    tlbp_resolve #(
        .NUM_ENT (NUM_ENT),
        .PFN_W   (PFN_W)
    ) u_resolve (
        .ent_pfn      (ent_pfn),
        .ent_vld      (ent_vld),
        .ent_dty      (ent_dty),
        .hit_any      (hit_any),
        .hit_idx      (hit_idx),
        .half_sel     (lk_vaddr[PAGE_OFS_W]),
        .is_write     (lk_write),
        .page_ofs     (lk_vaddr[PAGE_OFS_W-1:0]),
        .res_code     (res_code),
        .res_paddr    (res_paddr),
        .res_writable (res_writable)
    );

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            writable;
        logic [1:0]      code;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (lk_valid) begin
            rsp_d.valid    = 1'b1;
            rsp_d.paddr    = res_paddr;
            rsp_d.writable = res_writable;
            rsp_d.code     = res_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_paddr    = rsp_q.paddr;
    assign rsp_writable = rsp_q.writable;
    assign rsp_code     = rsp_q.code;

endmodule

// File: rtl/tlbp_lookup_chk.sv
module tlbp_lookup_chk #(
    parameter int unsigned VA_W = 32,
    parameter int unsigned PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_write,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_writable,
    input logic [1:0]      rsp_code
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R9

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R9

    AST_FAULT_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'b00) |-> (!rsp_writable && rsp_paddr == '0)); // R8

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b00) |-> (rsp_paddr[11:0] == $past(lk_vaddr[11:0]))); // R2

    AST_MODIFY_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b11) |-> $past(lk_write)); // R5

    AST_STORE_HIT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b00 && $past(lk_write)) |-> rsp_writable); // R4

endmodule

bind tlbp_lookup tlbp_lookup_chk #(
    .VA_W (VA_W),
    .PA_W (PA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_vaddr     (lk_vaddr),
    .lk_write     (lk_write),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_writable (rsp_writable),
    .rsp_code     (rsp_code)
);

// File: tb/tlbp_lookup_test.sv
module tlbp_lookup_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_tag = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn_even = '0;
    logic        wr_valid_even = 1'b0;
    logic        wr_dirty_even = 1'b0;
    logic [19:0] wr_pfn_odd = '0;
    logic        wr_valid_odd = 1'b0;
    logic        wr_dirty_odd = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_writable;
    logic [1:0]  rsp_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbp_lookup uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_valid      (lk_valid),
        .lk_vaddr      (lk_vaddr),
        .lk_write      (lk_write),
        .lk_asid       (lk_asid),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_tag        (wr_tag),
        .wr_asid       (wr_asid),
        .wr_global     (wr_global),
        .wr_pfn_even   (wr_pfn_even),
        .wr_valid_even (wr_valid_even),
        .wr_dirty_even (wr_dirty_even),
        .wr_pfn_odd    (wr_pfn_odd),
        .wr_valid_odd  (wr_valid_odd),
        .wr_dirty_odd  (wr_dirty_odd),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_writable  (rsp_writable),
        .rsp_code      (rsp_code)
    );

    localparam logic [1:0] C_HIT = 2'b00, C_MISS = 2'b01, C_INV = 2'b10, C_MOD = 2'b11;

    function automatic logic [31:0] mk_va(input logic [18:0] tag, input logic odd, input logic [11:0] ofs);
        return {tag, odd, ofs};
    endfunction

    task automatic expect_rsp(input string req, input logic vld, input logic [1:0] code,
                              input logic [31:0] pa, input logic wrb);
        checks++;
        if (rsp_valid !== vld || rsp_code !== code || rsp_paddr !== pa || rsp_writable !== wrb) begin
            failures++;
            $display("FAIL %s: got valid=%0b code=%0b paddr=%h wr=%0b, expected valid=%0b code=%0b paddr=%h wr=%0b",
                     req, rsp_valid, rsp_code, rsp_paddr, rsp_writable, vld, code, pa, wrb);
        end
    endtask

    task automatic load_entry(input logic [3:0] idx, input logic [18:0] tag, input logic [7:0] asid,
                              input logic glb, input logic [19:0] pe, input logic ve, input logic de,
                              input logic [19:0] po, input logic vo, input logic dodd);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_tag = tag; wr_asid = asid; wr_global = glb;
        wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dodd;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic wr, input logic [7:0] asid);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_asid = asid;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        expect_rsp("R11 reset output", 1'b0, 2'b00, 32'h0, 1'b0);
        lookup(32'h0000_0123, 1'b0, 8'h00);
        expect_rsp("R11 pair0 invalid", 1'b1, C_INV, 32'h0, 1'b0);
        lookup(32'h0000_5000, 1'b0, 8'h00);
        expect_rsp("R11 R6 other pair misses", 1'b1, C_MISS, 32'h0, 1'b0);
    endtask

    task automatic t_halves();
        load_entry(4'd1, 19'h12345, 8'h05, 1'b0, 20'hAAAAA, 1'b1, 1'b1, 20'h55555, 1'b1, 1'b0);
        lookup(mk_va(19'h12345, 1'b0, 12'h678), 1'b0, 8'h05);
        expect_rsp("R2 R4 even read", 1'b1, C_HIT, 32'hAAAAA678, 1'b1);
        lookup(mk_va(19'h12345, 1'b1, 12'h678), 1'b0, 8'h05);
        expect_rsp("R2 R4 odd read-only", 1'b1, C_HIT, 32'h55555678, 1'b0);
    endtask

    task automatic t_modify();
        lookup(mk_va(19'h12345, 1'b1, 12'hFFF), 1'b1, 8'h05);
        expect_rsp("R5 write clean half", 1'b1, C_MOD, 32'h0, 1'b0);
        lookup(mk_va(19'h12345, 1'b0, 12'h000), 1'b1, 8'h05);
        expect_rsp("R4 write dirty half", 1'b1, C_HIT, 32'hAAAAA000, 1'b1);
    endtask

    task automatic t_invalid();
        load_entry(4'd2, 19'h00100, 8'h05, 1'b0, 20'h11111, 1'b0, 1'b1, 20'h22222, 1'b1, 1'b0);
        lookup(mk_va(19'h00100, 1'b0, 12'h010), 1'b0, 8'h05);
        expect_rsp("R3 read invalid half", 1'b1, C_INV, 32'h0, 1'b0);
        lookup(mk_va(19'h00100, 1'b0, 12'h010), 1'b1, 8'h05);
        expect_rsp("R3 write invalid half", 1'b1, C_INV, 32'h0, 1'b0);
    endtask

    task automatic t_asid();
        lookup(mk_va(19'h12345, 1'b0, 12'h678), 1'b0, 8'h06);
        expect_rsp("R1 R6 asid mismatch", 1'b1, C_MISS, 32'h0, 1'b0);
        load_entry(4'd15, 19'h7FFFF, 8'h00, 1'b1, 20'hCAFE1, 1'b1, 1'b1, 20'h0BEEF, 1'b0, 1'b0);
        lookup(32'hFFFF_E123, 1'b1, 8'h99);
        expect_rsp("R1 global bypass", 1'b1, C_HIT, 32'hCAFE1123, 1'b1);
    endtask

    task automatic t_priority();
        load_entry(4'd9, 19'h40000, 8'h01, 1'b0, 20'h99999, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
        load_entry(4'd5, 19'h40000, 8'h01, 1'b0, 20'h55500, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
        lookup(mk_va(19'h40000, 1'b0, 12'h00C), 1'b0, 8'h01);
        expect_rsp("R7 lowest index wins", 1'b1, C_HIT, 32'h5550000C, 1'b0);
        load_entry(4'd5, 19'h40001, 8'h01, 1'b0, 20'h55500, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
        lookup(mk_va(19'h40000, 1'b0, 12'h00C), 1'b0, 8'h01);
        expect_rsp("R7 R10 fallback to index 9", 1'b1, C_HIT, 32'h9999900C, 1'b0);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd9; wr_tag = 19'h40000; wr_asid = 8'h01; wr_global = 1'b0;
        wr_pfn_even = 20'h77777; wr_valid_even = 1'b1; wr_dirty_even = 1'b1;
        wr_pfn_odd = 20'h0; wr_valid_odd = 1'b0; wr_dirty_odd = 1'b0;
        lk_valid = 1'b1; lk_vaddr = mk_va(19'h40000, 1'b0, 12'h0F0); lk_write = 1'b0; lk_asid = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        expect_rsp("R10 same-cycle sees old", 1'b1, C_HIT, 32'h999990F0, 1'b0);
        lookup(mk_va(19'h40000, 1'b0, 12'h0F0), 1'b0, 8'h01);
        expect_rsp("R10 next cycle sees new", 1'b1, C_HIT, 32'h777770F0, 1'b1);
    endtask

    task automatic t_idle();
        lookup(mk_va(19'h12345, 1'b0, 12'h001), 1'b0, 8'h05);
        @(negedge clk);
        expect_rsp("R9 idle after response", 1'b0, 2'b00, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_halves();
        t_modify();
        t_invalid();
        t_asid();
        t_priority();
        t_write_timing();
        t_idle();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule